// File: doc/BRIEF.md
# Quadrature Encoder Position Counter

This block turns the two phase-shifted square waves of an incremental rotary encoder, here called channel A and channel B, into an up/down position count. Both pins are brought into the system clock domain through two-flop synchronisers. Each channel can have its polarity inverted and can pass through a glitch filter. A change detector then finds channel edges. A run-time mode picks which channel's edges are counted. The level of the other channel at the moment of a counted edge decides whether the count goes up or down.

The count runs between zero and a programmable reload limit and wraps at both ends. Every wrap sets a sticky update flag that software clears. A change on both channels in the same clock cycle cannot be a legal quadrature step. It is refused and recorded in a sticky error flag. Software can load a start value, gate counting with an enable, and read the direction of the last counted edge.

Top module: `qenc_top`

## Requirements
- R1: With `mode` = 2'b00, only channel A edges are counted. After an A edge the count goes up when the new A level differs from B, and down when it equals B. One full forward quadrature cycle (AB = 00,10,11,01,00) adds 2.
- R2: With `mode` = 2'b01, only channel B edges are counted. After a B edge the count goes up when the new B level equals A, and down otherwise. One full forward cycle adds 2.
- R3: With `mode` = 2'b10 or 2'b11, edges of both channels are counted with the rules of R1 and R2. One forward cycle adds 4 and one reverse cycle (AB = 00,01,11,10,00) subtracts 4.
- R4: `inv_a`/`inv_b` = 1 inverts that pin before decoding, so a given pin sequence counts in the opposite direction. With both at 0 the pins are used as they are.
- R5: When both decoded channels change in the same clock cycle while enabled, the count does not change and `err_flag` is set. It stays set until `flag_clr`.
- R6: A counted up step at `count` == `arr` gives `count` = 0 and sets `upd_flag`.
- R7: A counted down step at `count` == 0 gives `count` = `arr` and sets `upd_flag`.
- R8: `upd_flag` stays set until a cycle with `flag_clr` = 1 and no new wrap. A wrap in that same cycle wins.
- R9: `load` = 1 writes `load_val` into `count` on the next clock edge, with priority over any counted step.
- R10: While `en` = 0, edges do not change `count`, `dir_up` or the flags. Edges seen while disabled are not counted later.
- R11: With `filt_len` = 0 a pin change reaches the counter unfiltered. The count changes on the third rising clock edge after the pin changes. With `filt_len` = N > 0, a new level is accepted only after it has been held for N consecutive clocks, so shorter pulses are dropped.
- R12: After reset, `count` = 0, `upd_flag` = 0, `err_flag` = 0 and `dir_up` = 1. `dir_up` then shows the direction of the most recent counted edge (1 = up).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| enc_a | input | 1 | Encoder channel A pin, asynchronous |
| enc_b | input | 1 | Encoder channel B pin, asynchronous |
| inv_a | input | 1 | Invert channel A |
| inv_b | input | 1 | Invert channel B |
| mode | input | 2 | Counted edges: 00 A only, 01 B only, 1x both |
| filt_len | input | FILT_W | Filter hold length in clocks, 0 = no filter |
| en | input | 1 | Counting enable |
| load | input | 1 | Load `load_val` into the count |
| load_val | input | CNT_W | Start value for the count |
| arr | input | CNT_W | Auto-reload limit (top of the count range) |
| flag_clr | input | 1 | Clears `upd_flag` and `err_flag` |
| count | output | CNT_W | Position count |
| dir_up | output | 1 | Direction of the last counted edge, 1 = up |
| upd_flag | output | 1 | Sticky wrap flag |
| err_flag | output | 1 | Sticky invalid-transition flag |

## Verification
The hardest case to reach is an invalid transition. Both decoded channels have to change in the same clock cycle, after synchronisation and filtering. The bench drives both pins on the same falling edge, with the filter off, so the two synchronisers carry the change through in lockstep. The bench also shows the case in reverse: a pulse one clock shorter than the filter length never reaches the decoder at all.

// File: rtl/qenc_pkg.sv
package qenc_pkg;

    typedef enum logic [1:0] {
        MODE_A_ONLY = 2'b00,
        MODE_B_ONLY = 2'b01,
        MODE_BOTH   = 2'b10,
        MODE_BOTH_X = 2'b11
    } enc_mode_e;

    typedef struct packed {
        logic valid;   // a counted edge this cycle
        logic up;      // its direction
        logic bad;     // both channels moved together
    } step_t;

    // Direction of an edge: an A edge counts up when A and B now differ,
    // a B edge counts up when A and B now agree.
    function automatic logic edge_is_up(input logic from_a, input logic a, input logic b);
        return from_a ? (a ^ b) : ~(a ^ b);
    endfunction

endpackage

// File: rtl/qenc_input_cond.sv
module qenc_input_cond #(
    parameter int FILT_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pin,
    input  logic              inv,
    input  logic [FILT_W-1:0] filt_len,
    output logic              lvl
);
    logic              sync1, sync2;
    logic              held;
    logic [FILT_W-1:0] run;

    // Synchroniser: no reset needed, it only carries the pin.
    always_ff @(posedge clk) begin
        sync1 <= pin ^ inv;
        sync2 <= sync1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            held <= sync2;
            run  <= '0;
        end else if (sync2 == held) begin
            run <= '0;
        end else if (filt_len == '0 || ({1'b0, run} + 1'b1) >= {1'b0, filt_len}) begin
            held <= sync2;
            run  <= '0;
        end else begin
            run <= run + 1'b1;
        end
    end

    assign lvl = (filt_len == '0) ? sync2 : held;

    // R11
    filter_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (filt_len != '0 && $past(filt_len) != '0 && held != $past(held)) |-> (held == $past(sync2)));

endmodule

// File: rtl/qenc_step_decode.sv
module qenc_step_decode
    import qenc_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      a_lvl,
    input  logic      b_lvl,
    input  logic      en,
    input  logic [1:0] mode,
    output step_t     step
);
    logic      prev_a, prev_b;
    logic      chg_a, chg_b, use_a, use_b;
    enc_mode_e md;

    always_ff @(posedge clk) begin
        prev_a <= a_lvl;
        prev_b <= b_lvl;
        if (rst) begin
            prev_a <= a_lvl;
            prev_b <= b_lvl;
        end
    end

    always_comb begin
        md    = enc_mode_e'(mode);
        chg_a = a_lvl ^ prev_a;
        chg_b = b_lvl ^ prev_b;
        use_a = (md != MODE_B_ONLY);
        use_b = (md != MODE_A_ONLY);
        step.bad   = en & chg_a & chg_b;
        step.valid = en & ~(chg_a & chg_b) & ((chg_a & use_a) | (chg_b & use_b));
        step.up    = edge_is_up(chg_a, a_lvl, b_lvl);
    end

endmodule

// File: rtl/qenc_wrap_counter.sv
module qenc_wrap_counter
    import qenc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  step_t            step,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] arr,
    input  logic             flag_clr,
    output logic [CNT_W-1:0] count,
    output logic             dir_up,
    output logic             upd_flag,
    output logic             err_flag
);
    logic             wrap;
    logic [CNT_W-1:0] next_cnt;

    always_comb begin
        wrap     = 1'b0;
        next_cnt = count;
        if (step.valid && !load) begin
            if (step.up) begin
                wrap     = (count == arr);
                next_cnt = wrap ? '0 : count + 1'b1;
            end else begin
                wrap     = (count == '0);
                next_cnt = wrap ? arr : count - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count    <= '0;
            dir_up   <= 1'b1;
            upd_flag <= 1'b0;
            err_flag <= 1'b0;
        end else begin
            count <= load ? load_val : next_cnt;
            if (step.valid && !load) dir_up <= step.up;
            if (wrap)          upd_flag <= 1'b1;
            else if (flag_clr) upd_flag <= 1'b0;
            if (step.bad)      err_flag <= 1'b1;
            else if (flag_clr) err_flag <= 1'b0;
        end
    end

    // R6
    wrap_up_chk: assert property (@(posedge clk) disable iff (rst)
        (step.valid && step.up && !load && count == arr) |=> (count == '0 && upd_flag));
    // R7
    wrap_down_chk: assert property (@(posedge clk) disable iff (rst)
        (step.valid && !step.up && !load && count == '0) |=> (count == $past(arr) && upd_flag));
    // R5
    bad_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (step.bad && !load) |=> ($stable(count) && err_flag));
    // R9
    load_chk: assert property (@(posedge clk) disable iff (rst)
        load |=> (count == $past(load_val)));
    // R8
    upd_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (upd_flag && !flag_clr) |=> upd_flag);
    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!step.valid && !load) |=> $stable(count));

endmodule

// File: rtl/qenc_top.sv
module qenc_top
    import qenc_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int FILT_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enc_a,
    input  logic              enc_b,
    input  logic              inv_a,
    input  logic              inv_b,
    input  logic [1:0]        mode,
    input  logic [FILT_W-1:0] filt_len,
    input  logic              en,
    input  logic              load,
    input  logic [CNT_W-1:0]  load_val,
    input  logic [CNT_W-1:0]  arr,
    input  logic              flag_clr,
    output logic [CNT_W-1:0]  count,
    output logic              dir_up,
    output logic              upd_flag,
    output logic              err_flag
);
    localparam int NCH = 2;

    logic [NCH-1:0] pins, invs, lvls;
    step_t          step;

    assign pins = {enc_b, enc_a};
    assign invs = {inv_b, inv_a};

    for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
        qenc_input_cond #(.FILT_W(FILT_W)) u_cond (
            .clk      (clk),
            .rst      (rst),
            .pin      (pins[ch]),
            .inv      (invs[ch]),
            .filt_len (filt_len),
            .lvl      (lvls[ch])
        );
    end

    qenc_step_decode u_dec (
        .clk   (clk),
        .rst   (rst),
        .a_lvl (lvls[0]),
        .b_lvl (lvls[1]),
        .en    (en),
        .mode  (mode),
        .step  (step)
    );

    qenc_wrap_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .step     (step),
        .load     (load),
        .load_val (load_val),
        .arr      (arr),
        .flag_clr (flag_clr),
        .count    (count),
        .dir_up   (dir_up),
        .upd_flag (upd_flag),
        .err_flag (err_flag)
    );

endmodule

// File: tb/qenc_top_tb.sv
module qenc_top_tb;
    localparam int CNT_W  = 16;
    localparam int FILT_W = 4;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              enc_a = 1'b0, enc_b = 1'b0, inv_a = 1'b0, inv_b = 1'b0;
    logic [1:0]        mode = 2'b10;
    logic [FILT_W-1:0] filt_len = '0;
    logic              en = 1'b1, load = 1'b0, flag_clr = 1'b0;
    logic [CNT_W-1:0]  load_val = '0, arr = 16'd1000;
    logic [CNT_W-1:0]  count;
    logic              dir_up, upd_flag, err_flag;

    int n_chk = 0, n_bad = 0, ph = 0;

    always #5 clk = ~clk;

    qenc_top #(.CNT_W(CNT_W), .FILT_W(FILT_W)) u_dut (
        .clk(clk), .rst(rst), .enc_a(enc_a), .enc_b(enc_b),
        .inv_a(inv_a), .inv_b(inv_b), .mode(mode), .filt_len(filt_len),
        .en(en), .load(load), .load_val(load_val), .arr(arr),
        .flag_clr(flag_clr), .count(count), .dir_up(dir_up),
        .upd_flag(upd_flag), .err_flag(err_flag)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // one quadrature step: +1 forward, -1 reverse
    task automatic qstep(input int d);
        @(negedge clk);
        ph = (ph + 4 + d) % 4;
        enc_a = (ph == 1 || ph == 2);
        enc_b = (ph >= 2);
        settle(6 + int'(filt_len));
    endtask

    task automatic qcycle(input int d);
        for (int i = 0; i < 4; i++) qstep(d);
    endtask

    task automatic do_load(input int v);
        @(negedge clk);
        load = 1'b1; load_val = CNT_W'(v);
        @(negedge clk);
        load = 1'b0;
    endtask

    task automatic pulse_clr();
        @(negedge clk); flag_clr = 1'b1;
        @(negedge clk); flag_clr = 1'b0;
    endtask

    task automatic t_reset();
        check("R12 count after reset", count, 0);
        check("R12 upd after reset", upd_flag, 0);
        check("R12 err after reset", err_flag, 0);
        check("R12 dir after reset", dir_up, 1);
    endtask

    task automatic t_latency();
        mode = 2'b10; do_load(50);
        @(negedge clk); ph = 1; enc_a = 1'b1;
        @(negedge clk); @(negedge clk);
        check("R11 no change after two edges", count, 50);
        @(negedge clk);
        check("R11 change on third edge", count, 51);
        qstep(-1);
        check("R11 back", count, 50);
    endtask

    task automatic t_mode_a();
        mode = 2'b00; do_load(100);
        qcycle(1);
        check("R1 A-only forward", count, 102);
        check("R12 dir up", dir_up, 1);
        qcycle(-1);
        check("R1 A-only reverse", count, 100);
        check("R12 dir down", dir_up, 0);
    endtask

    task automatic t_mode_b();
        mode = 2'b01; do_load(200);
        qcycle(1);
        check("R2 B-only forward", count, 202);
        qstep(-1);
        check("R2 B-only single reverse B edge", count, 201);
    endtask

    task automatic t_mode_ab();
        while (ph != 0) qstep(-1);
        mode = 2'b10; do_load(300);
        qcycle(1);
        check("R3 both forward", count, 304);
        qcycle(-1); qcycle(-1);
        check("R3 both reverse", count, 296);
        mode = 2'b11; qcycle(1);
        check("R3 mode 11 forward", count, 300);
    endtask

    task automatic t_polarity();
        mode = 2'b00; do_load(400);
        @(negedge clk); inv_b = 1'b1; settle(6);
        check("R4 B inversion alone ignored in A-only", count, 400);
        qcycle(1);
        check("R4 inverted B reverses direction", count, 398);
        @(negedge clk); inv_b = 1'b0; settle(6);
        qcycle(1);
        check("R4 normal polarity restored", count, 400);
    endtask

    task automatic t_invalid();
        mode = 2'b10; do_load(500); pulse_clr();
        @(negedge clk); enc_a = 1'b1; enc_b = 1'b1; settle(6);
        check("R5 count held on double change", count, 500);
        check("R5 err set", err_flag, 1);
        @(negedge clk); enc_a = 1'b0; enc_b = 1'b0; settle(6);
        check("R5 count held on return", count, 500);
        check("R5 err sticky", err_flag, 1);
        pulse_clr();
        check("R5 err cleared", err_flag, 0);
    endtask

    task automatic t_wrap();
        arr = 16'd7; mode = 2'b10; do_load(7); pulse_clr();
        qstep(1);
        check("R6 wrap up to zero", count, 0);
        check("R6 upd set", upd_flag, 1);
        qstep(1);
        check("R8 upd sticky", upd_flag, 1);
        pulse_clr();
        check("R8 upd cleared", upd_flag, 0);
        do_load(0); qstep(-1);
        check("R7 wrap down to arr", count, 7);
        check("R7 upd set", upd_flag, 1);
        check("R12 dir down after wrap", dir_up, 0);
        pulse_clr(); arr = 16'd1000;
    endtask

    task automatic t_enable();
        do_load(600);
        @(negedge clk); en = 1'b0;
        qcycle(1); qstep(1);
        check("R10 disabled holds count", count, 600);
        @(negedge clk); en = 1'b1; settle(4);
        check("R10 no late count", count, 600);
        qstep(1);
        check("R10 counting resumes", count, 601);
        do_load(777);
        check("R9 load value", count, 777);
    endtask

    task automatic t_filter();
        while (ph != 0) qstep(-1);
        mode = 2'b00; filt_len = 4'd4; do_load(700);
        @(negedge clk); enc_a = 1'b1;
        settle(3);
        enc_a = 1'b0; settle(12);
        check("R11 short pulse rejected", count, 700);
        qstep(1);
        check("R11 held level accepted", count, 701);
        qstep(-1);
        filt_len = '0;
        check("R11 filtered reverse", count, 700);
    endtask

    initial begin
        settle(4);
        rst = 1'b0;
        settle(2);
        t_reset();
        t_latency();
        t_mode_a();
        t_mode_b();
        t_mode_ab();
        t_polarity();
        t_invalid();
        t_wrap();
        t_enable();
        t_filter();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #1000000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule